// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM Cycle Controller

This block is the clocked control front end of a pipelined synchronous burst SRAM, together with a small byte-laned storage array. On every rising clock edge it samples three chip selects, two address strobes, a burst-advance input, the write controls and a sleep request. It then classifies the cycle as one of six kinds. Four of them act on the array: starting a read, starting a write, advancing a burst and holding a burst. The other two do nothing: a deselect, and a cycle that is not accepted. Read data passes through one output register. The drive-enable for the data bus is formed without a clock from the output-enable input.

The low address bits of a burst come from a wrapping sequencer. A mode pin selects linear (add) or interleaved (XOR) ordering. A sleep state machine parks the device in a low-power snooze. Entering snooze takes two clock edges. After the request is withdrawn, the first two edges still ignore all strobes. The array keeps its contents throughout.

Sleep state machine: SLP_RUN goes to SLP_ENTER when zz is high. SLP_ENTER goes to SLP_SNOOZE if zz is still high, otherwise to SLP_WAKE. SLP_SNOOZE goes to SLP_WAKE when zz is low. SLP_WAKE goes to SLP_RUN if zz is low, otherwise back to SLP_ENTER. Access state machine: ACC_IDLE, ACC_READ and ACC_WRITE. A cycle that starts a read moves it to ACC_READ and a cycle that starts a write moves it to ACC_WRITE. A deselect or an unaccepted cycle returns it to ACC_IDLE. An advance or hold cycle leaves the state unchanged.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While reset is active and right after it, dq_oe is 0 and sleeping is 0.
- R2: A read accepted at clock edge k puts the addressed word on rdata after edge k+1, and not after edge k.
- R3: With pri_n low, a low proc_n starts a read whatever gw_n, bwe_n, be_n or ctrl_n are; the array word is left unchanged.
- R4: With ctrl_n low (proc_n high, selected), the cycle is a write when gw_n is low (all lanes) or when bwe_n is low and some be_n bit is low. Lane i is byte [8i+7:8i] and is enabled by be_n[i]=0. Otherwise the cycle is a read.
- R5: pri_n high with ctrl_n low is a deselect, and proc_n is ignored while pri_n is high. With pri_n low but sec_hi=0 or sec_lo_n=1, either strobe gives a deselect. A deselect never writes and leaves dq_oe low two edges later.
- R6: With both strobes high and adv_n low, a burst moves to its next word in the same access type. With burst_lin=1 the low two bits step as base+n mod 4; with burst_lin=0 they step as base XOR n.
- R7: With both strobes high and adv_n high, an active burst repeats its current address.
- R8: dq_oe follows oe_n without a clock: it is high only while oe_n is low, and it is forced low during a cycle that is decoded as a write.
- R9: zz high forces dq_oe low at once, and a read pending at that moment is dropped. sleeping rises after the second edge that samples zz high. The array contents survive the snooze.
- R10: After zz falls, strobes on the first two edges are ignored, and an access on the third edge is accepted.
- R11: A burst started as a write writes its advanced addresses, using the lane enables of each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | External word address |
| pri_n | input | 1 | Primary chip select, active low |
| sec_hi | input | 1 | Secondary chip select, active high |
| sec_lo_n | input | 1 | Secondary chip select, active low |
| proc_n | input | 1 | Processor address strobe, active low |
| ctrl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| be_n | input | DATA_W/8 | Per-lane byte enables, active low |
| oe_n | input | 1 | Output enable, not clocked, active low |
| zz | input | 1 | Sleep request, active high |
| burst_lin | input | 1 | 1 selects linear, 0 interleaved burst order |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| dq_oe | output | 1 | Data bus drive enable |
| sleeping | output | 1 | High while in snooze |

## Verification
The bench builds the block with ADDR_W=6, DATA_W=32 and BURST_W=2. That gives a 64-word array with four byte lanes and a four-beat wrapping burst, so every start offset of both burst orders fits in one 4-word block and can be walked from a table. Four lanes make a mixed lane mask observable. The short array lets directed tests hit the snooze entry, the two ignored wake edges and the first accepted edge within a few dozen cycles.

// File: rtl/sram_cyc_pkg.sv
package sram_cyc_pkg;

    typedef enum logic [1:0] {
        SLP_RUN    = 2'd0,
        SLP_ENTER  = 2'd1,
        SLP_SNOOZE = 2'd2,
        SLP_WAKE   = 2'd3
    } slp_state_e;

    typedef enum logic [2:0] {
        CYC_NONE     = 3'd0,
        CYC_DESEL    = 3'd1,
        CYC_START_RD = 3'd2,
        CYC_START_WR = 3'd3,
        CYC_ADVANCE  = 3'd4,
        CYC_HOLD     = 3'd5
    } cyc_kind_e;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_state_e;

endpackage

// File: rtl/sram_sleep_fsm.sv
module sram_sleep_fsm
    import sram_cyc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic zz,
    output logic accept,
    output logic sleeping
);

    slp_state_e st_q;
    slp_state_e st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= SLP_RUN;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SLP_RUN:    if (zz) st_d = SLP_ENTER;
            SLP_ENTER:  st_d = zz ? SLP_SNOOZE : SLP_WAKE;
            SLP_SNOOZE: if (!zz) st_d = SLP_WAKE;
            SLP_WAKE:   st_d = zz ? SLP_ENTER : SLP_RUN;
            default:    st_d = SLP_RUN;
        endcase
    end

    // Accesses only in full-run state with no pending sleep request
    always_comb begin
        accept   = (st_q == SLP_RUN) && !zz;
        sleeping = (st_q == SLP_SNOOZE);
    end

endmodule

// File: rtl/sram_cycle_dec.sv
module sram_cycle_dec
    import sram_cyc_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             accept,
    input  logic             pri_n,
    input  logic             sec_hi,
    input  logic             sec_lo_n,
    input  logic             proc_n,
    input  logic             ctrl_n,
    input  logic             adv_n,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] be_n,
    output cyc_kind_e        kind,
    output logic [LANES-1:0] lane_we
);

    logic sec_ok;
    logic wr_int;
    logic proc_take;

    always_comb begin
        sec_ok    = sec_hi && !sec_lo_n;
        wr_int    = !gw_n || (!bwe_n && !(&be_n));
        proc_take = !proc_n && !pri_n;
        lane_we   = !gw_n ? {LANES{1'b1}} : (!bwe_n ? ~be_n : {LANES{1'b0}});

        if (!accept) begin
            kind = CYC_NONE;
        end else if (proc_take) begin
            // processor strobe always reads; write inputs are ignored
            kind = sec_ok ? CYC_START_RD : CYC_DESEL;
        end else if (!ctrl_n) begin
            if (!pri_n && sec_ok) begin
                kind = wr_int ? CYC_START_WR : CYC_START_RD;
            end else begin
                kind = CYC_DESEL;
            end
        end else begin
            kind = adv_n ? CYC_HOLD : CYC_ADVANCE;
        end
    end

endmodule

// File: rtl/sram_burst_seq.sv
module sram_burst_seq #(
    parameter int BURST_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic               lin,
    input  logic [BURST_W-1:0] base_in,
    output logic [BURST_W-1:0] seq_low
);

    logic [BURST_W-1:0] base_q;
    logic [BURST_W-1:0] cnt_q;
    logic [BURST_W-1:0] cnt_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            base_q <= base_in;
            cnt_q  <= '0;
        end else if (step) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        cnt_sel = step ? (cnt_q + 1'b1) : cnt_q;
        if (load) begin
            seq_low = base_in;
        end else if (lin) begin
            seq_low = base_q + cnt_sel;
        end else begin
            seq_low = base_q ^ cnt_sel;
        end
    end

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
    import sram_cyc_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int DATA_W  = 32,
    parameter int BURST_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  pri_n,
    input  logic                  sec_hi,
    input  logic                  sec_lo_n,
    input  logic                  proc_n,
    input  logic                  ctrl_n,
    input  logic                  adv_n,
    input  logic                  gw_n,
    input  logic                  bwe_n,
    input  logic [DATA_W/8-1:0]   be_n,
    input  logic                  oe_n,
    input  logic                  zz,
    input  logic                  burst_lin,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    output logic                  dq_oe,
    output logic                  sleeping
);

    localparam int LANES = DATA_W / 8;
    localparam int DEPTH = 1 << ADDR_W;
    localparam int HI_W  = ADDR_W - BURST_W;

    logic              accept;
    cyc_kind_e         kind;
    logic [LANES-1:0]  lane_we;
    logic [BURST_W-1:0] seq_low;

    acc_state_e        acc_q;
    acc_state_e        acc_d;
    logic [HI_W-1:0]   hi_q;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] rd_addr_q;
    logic              rd_v_q;
    logic              drv_q;
    logic [DATA_W-1:0] dout_q;
    logic [DATA_W-1:0] rd_word;
    logic              do_rd;
    logic              do_wr;
    logic              load;
    logic              step;

    sram_sleep_fsm slp_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .zz       (zz),
        .accept   (accept),
        .sleeping (sleeping)
    );

    sram_cycle_dec #(.LANES(LANES)) dec_i (
        .accept   (accept),
        .pri_n    (pri_n),
        .sec_hi   (sec_hi),
        .sec_lo_n (sec_lo_n),
        .proc_n   (proc_n),
        .ctrl_n   (ctrl_n),
        .adv_n    (adv_n),
        .gw_n     (gw_n),
        .bwe_n    (bwe_n),
        .be_n     (be_n),
        .kind     (kind),
        .lane_we  (lane_we)
    );

    sram_burst_seq #(.BURST_W(BURST_W)) seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step    (step),
        .lin     (burst_lin),
        .base_in (addr[BURST_W-1:0]),
        .seq_low (seq_low)
    );

    // Access state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= ACC_IDLE;
        end else begin
            acc_q <= acc_d;
        end
    end

    // Next access state
    always_comb begin
        acc_d = acc_q;
        unique case (kind)
            CYC_NONE,
            CYC_DESEL:    acc_d = ACC_IDLE;
            CYC_START_RD: acc_d = ACC_READ;
            CYC_START_WR: acc_d = ACC_WRITE;
            CYC_ADVANCE,
            CYC_HOLD:     acc_d = acc_q;
            default:      acc_d = ACC_IDLE;
        endcase
    end

    // Per-cycle actions
    always_comb begin
        do_rd = 1'b0;
        do_wr = 1'b0;
        unique case (kind)
            CYC_START_RD: do_rd = 1'b1;
            CYC_START_WR: do_wr = 1'b1;
            CYC_ADVANCE,
            CYC_HOLD: begin
                do_rd = (acc_q == ACC_READ);
                do_wr = (acc_q == ACC_WRITE);
            end
            default: begin
                do_rd = 1'b0;
                do_wr = 1'b0;
            end
        endcase
        load     = (kind == CYC_START_RD) || (kind == CYC_START_WR);
        step     = (kind == CYC_ADVANCE) && (acc_q != ACC_IDLE);
        cur_addr = load ? addr : {hi_q, seq_low};
    end

    // Address high part and read pipeline
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q      <= '0;
            rd_addr_q <= '0;
            rd_v_q    <= 1'b0;
            drv_q     <= 1'b0;
            dout_q    <= '0;
        end else begin
            if (load) begin
                hi_q <= addr[ADDR_W-1:BURST_W];
            end
            if (do_rd) begin
                rd_addr_q <= cur_addr;
            end
            rd_v_q <= do_rd;
            drv_q  <= rd_v_q;
            if (rd_v_q) begin
                dout_q <= rd_word;
            end
        end
    end

    // Byte-laned storage array
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] bank [DEPTH];

        always_ff @(posedge clk) begin
            if (do_wr && lane_we[g]) begin
                bank[cur_addr] <= wdata[g*8 +: 8];
            end
        end

        assign rd_word[g*8 +: 8] = bank[rd_addr_q];
    end

    // Output enable path, not clocked
    always_comb begin
        rdata = dout_q;
        dq_oe = drv_q && !oe_n && !do_wr && !zz;
    end

endmodule

// File: rtl/sram_cycle_chk.sv
module sram_cycle_chk (
    input logic clk,
    input logic rst_n,
    input logic pri_n,
    input logic sec_hi,
    input logic sec_lo_n,
    input logic proc_n,
    input logic ctrl_n,
    input logic gw_n,
    input logic oe_n,
    input logic zz,
    input logic dq_oe,
    input logic sleeping
);

    AST_DRIVE_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> !oe_n); // R8

    AST_WRITE_MASKS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_n && proc_n && !pri_n && sec_hi && !sec_lo_n && !gw_n) |-> !dq_oe); // R8

    AST_SLEEP_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        zz |-> !dq_oe); // R9

    AST_SLEEP_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        (sleeping && !$past(sleeping)) |-> ($past(zz) && $past(zz, 2))); // R9

    AST_WAKE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleeping) |-> (!dq_oe ##1 !dq_oe)); // R10

    AST_DESEL_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (pri_n && !ctrl_n) |=> ##1 !dq_oe); // R5

endmodule

bind sram_cycle_ctrl sram_cycle_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pri_n    (pri_n),
    .sec_hi   (sec_hi),
    .sec_lo_n (sec_lo_n),
    .proc_n   (proc_n),
    .ctrl_n   (ctrl_n),
    .gw_n     (gw_n),
    .oe_n     (oe_n),
    .zz       (zz),
    .dq_oe    (dq_oe),
    .sleeping (sleeping)
);

// File: tb/sram_cycle_ctrl_tb.sv
module sram_cycle_ctrl_tb_top;

    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;
    localparam logic [3:0] HI = 4'd5;

    // {lin, base, beat1, beat2, beat3}
    localparam logic [8:0] VEC [8] = '{
        9'b1_00_01_10_11,
        9'b1_01_10_11_00,
        9'b1_10_11_00_01,
        9'b1_11_00_01_10,
        9'b0_00_01_10_11,
        9'b0_01_00_11_10,
        9'b0_10_11_00_01,
        9'b0_11_10_01_00
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic [ADDR_W-1:0] addr;
    logic              pri_n, sec_hi, sec_lo_n, proc_n, ctrl_n, adv_n;
    logic              gw_n, bwe_n, oe_n, zz, burst_lin;
    logic [LANES-1:0]  be_n;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] rdata;
    logic              dq_oe;
    logic              sleeping;

    logic [DATA_W-1:0] shadow [64];
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sram_cycle_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BURST_W(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .pri_n(pri_n), .sec_hi(sec_hi),
        .sec_lo_n(sec_lo_n), .proc_n(proc_n), .ctrl_n(ctrl_n), .adv_n(adv_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .be_n(be_n), .oe_n(oe_n), .zz(zz),
        .burst_lin(burst_lin), .wdata(wdata), .rdata(rdata), .dq_oe(dq_oe),
        .sleeping(sleeping)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic nop();
        pri_n = 1'b1; ctrl_n = 1'b0; proc_n = 1'b1; adv_n = 1'b1;
        gw_n = 1'b1; bwe_n = 1'b1; be_n = '1; sec_hi = 1'b1; sec_lo_n = 1'b0;
    endtask

    task automatic start_rd(input logic [ADDR_W-1:0] a);
        nop();
        pri_n = 1'b0; proc_n = 1'b0; ctrl_n = 1'b1; addr = a;
    endtask

    task automatic start_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                            input logic g, input logic b, input logic [LANES-1:0] e);
        nop();
        pri_n = 1'b0; proc_n = 1'b1; ctrl_n = 1'b0; addr = a;
        wdata = d; gw_n = g; bwe_n = b; be_n = e;
    endtask

    task automatic cont(input logic adv);
        nop();
        pri_n = 1'b0; ctrl_n = 1'b1; adv_n = adv;
    endtask

    task automatic read_check(input string tag, input logic [ADDR_W-1:0] a);
        start_rd(a); tick();
        nop(); tick();
        chk(tag, {31'd0, dq_oe}, 32'd1);
        chk(tag, rdata, shadow[a]);
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        nop();
        addr = '0; wdata = '0; oe_n = 1'b0; zz = 1'b0; burst_lin = 1'b1;
        rst_n = 1'b0;
        tick(); tick();
        chk("R1 dq_oe in reset", {31'd0, dq_oe}, 32'd0);
        chk("R1 sleeping in reset", {31'd0, sleeping}, 32'd0);
        rst_n = 1'b1;
        tick();
        chk("R1 dq_oe after reset", {31'd0, dq_oe}, 32'd0);

        // preload one 4-word block with full-word writes
        for (int a = 0; a < 4; a++) begin
            shadow[{HI, a[1:0]}] = 32'h5A5A_0000 | a;
            start_wr({HI, a[1:0]}, shadow[{HI, a[1:0]}], 1'b0, 1'b1, '1);
            tick();
            nop(); tick();
        end

        // table of burst orders: R6 (first beat also R2)
        for (int v = 0; v < 8; v++) begin
            logic [8:0] e;
            e = VEC[v];
            burst_lin = e[8];
            start_rd({HI, e[7:6]}); tick();
            cont(1'b0); tick();
            chk("R2 first beat", rdata, shadow[{HI, e[7:6]}]);
            tick();
            chk("R6 beat 1", rdata, shadow[{HI, e[5:4]}]);
            tick();
            chk("R6 beat 2", rdata, shadow[{HI, e[3:2]}]);
            nop(); tick();
            chk("R6 beat 3", rdata, shadow[{HI, e[1:0]}]);
            chk("R6 drive", {31'd0, dq_oe}, 32'd1);
            tick();
        end
        burst_lin = 1'b1;

        // R2 latency: nothing after edge k, data after k+1
        start_rd({HI, 2'd2}); tick();
        chk("R2 not yet driven", {31'd0, dq_oe}, 32'd0);
        nop(); tick();
        chk("R2 driven", {31'd0, dq_oe}, 32'd1);
        chk("R2 data", rdata, shadow[{HI, 2'd2}]);

        // R3 processor strobe wins over write inputs
        start_wr({HI, 2'd1}, 32'hDEAD_BEEF, 1'b0, 1'b0, '0);
        proc_n = 1'b0;
        tick();
        nop(); tick();
        chk("R3 read data", rdata, shadow[{HI, 2'd1}]);
        chk("R3 driven", {31'd0, dq_oe}, 32'd1);
        read_check("R3 array unchanged", {HI, 2'd1});

        // R4 lane write: lanes 0 and 2 enabled
        start_wr({HI, 2'd3}, 32'hFFFF_FFFF, 1'b1, 1'b0, 4'b1010);
        shadow[{HI, 2'd3}] = (shadow[{HI, 2'd3}] & 32'hFF00_FF00) | 32'h00FF_00FF;
        tick();
        nop(); tick();
        read_check("R4 lane merge", {HI, 2'd3});
        start_wr({HI, 2'd3}, 32'h0, 1'b1, 1'b1, 4'b0000);
        tick();
        nop(); tick();
        chk("R4 no-write is read drive", {31'd0, dq_oe}, 32'd1);
        chk("R4 no-write is read data", rdata, shadow[{HI, 2'd3}]);
        start_wr({HI, 2'd3}, 32'h0, 1'b1, 1'b0, 4'b1111);
        tick();
        nop(); tick();
        chk("R4 no lane is read", rdata, shadow[{HI, 2'd3}]);

        // R5 deselects
        tick();
        nop(); pri_n = 1'b1; proc_n = 1'b0; ctrl_n = 1'b1; addr = {HI, 2'd0};
        tick();
        nop(); tick();
        chk("R5 proc ignored when pri high", {31'd0, dq_oe}, 32'd0);
        start_rd({HI, 2'd0}); sec_hi = 1'b0;
        tick();
        nop(); tick();
        chk("R5 sec_hi low deselect", {31'd0, dq_oe}, 32'd0);
        start_wr({HI, 2'd0}, 32'h0, 1'b0, 1'b1, '1); sec_lo_n = 1'b1;
        tick();
        nop(); tick();
        chk("R5 sec_lo_n high deselect", {31'd0, dq_oe}, 32'd0);
        read_check("R5 deselect did not write", {HI, 2'd0});

        // R7 hold repeats address
        start_rd({HI, 2'd1}); tick();
        cont(1'b1); tick();
        chk("R7 first", rdata, shadow[{HI, 2'd1}]);
        tick();
        chk("R7 hold repeat", rdata, shadow[{HI, 2'd1}]);
        nop(); tick();
        chk("R7 hold again", rdata, shadow[{HI, 2'd1}]);

        // R8 output enable without clock, masked on write
        start_rd({HI, 2'd2}); tick();
        nop(); tick();
        chk("R8 drive with oe low", {31'd0, dq_oe}, 32'd1);
        oe_n = 1'b1; #1;
        chk("R8 oe high", {31'd0, dq_oe}, 32'd0);
        oe_n = 1'b0; #1;
        chk("R8 oe low again", {31'd0, dq_oe}, 32'd1);
        start_wr({HI, 2'd2}, 32'h1234_5678, 1'b0, 1'b1, '1); #1;
        chk("R8 masked by write", {31'd0, dq_oe}, 32'd0);
        shadow[{HI, 2'd2}] = 32'h1234_5678;
        tick();
        nop(); tick();

        // R11 write burst advance, interleaved
        burst_lin = 1'b0;
        start_wr({HI, 2'd1}, 32'h0BAD_F00D, 1'b0, 1'b1, '1); tick();
        cont(1'b0); gw_n = 1'b0; wdata = 32'h600D_CAFE; tick();
        nop(); tick();
        shadow[{HI, 2'd1}] = 32'h0BAD_F00D;
        shadow[{HI, 2'd0}] = 32'h600D_CAFE;
        read_check("R11 advanced write", {HI, 2'd0});
        read_check("R11 start write", {HI, 2'd1});
        burst_lin = 1'b1;

        // R9 sleep entry
        start_rd({HI, 2'd2}); tick();
        nop(); zz = 1'b1; #1;
        chk("R9 pending read dark", {31'd0, dq_oe}, 32'd0);
        tick();
        chk("R9 not asleep after one edge", {31'd0, sleeping}, 32'd0);
        tick();
        chk("R9 asleep after two edges", {31'd0, sleeping}, 32'd1);
        tick(); tick();

        // R10 recovery: two ignored edges, third accepted
        zz = 1'b0;
        start_wr({HI, 2'd3}, 32'hBBBB_BBBB, 1'b0, 1'b1, '1);
        tick();
        chk("R10 left snooze", {31'd0, sleeping}, 32'd0);
        tick();
        start_rd({HI, 2'd3}); tick();
        nop(); tick();
        chk("R10 third edge accepted", {31'd0, dq_oe}, 32'd1);
        chk("R10 wake write ignored", rdata, shadow[{HI, 2'd3}]);
        read_check("R9 contents kept", {HI, 2'd2});

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule